// File: doc/BRIEF.md
# Multi-Mode PRG Bank Mapper

This block turns a CPU address in the cartridge range 0x6000 to 0xFFFF into the number of an 8 KB page of program ROM. Its state is four 8-bit bank registers and two control bytes. The main control byte selects one of eight banking layouts and can open the 0x6000 window to ROM. The outer control byte supplies high-order bank bits, so that a large ROM can be split into independent slices.

The write-address decode sits outside the block. It raises one of three write strobes, together with an index and a data byte. The address path is purely combinational from the register state. A page number therefore follows `cpu_addr` within the same cycle, and it follows a register write from the cycle after the strobe.

Whatever the bank size of the active mode, the result is always given as an 8 KB page. A 16 KB bank is extended with CPU address bit 13. A 32 KB bank is extended with bits 14:13.

Top module: `prg_bank_mapper`

## Requirements
- R1: After reset every bank register holds 0xFF and both control bytes hold 0. The block is then in mode 0 with the window closed, so 0x8000-0xFFFF maps to pages 0x1C-0x1F.
- R2: A write strobe loads its register on the next rising clock edge. `bank_we` loads bank register `wr_idx`, `ctl_we` loads the main control byte and `outer_we` loads the outer control byte. Without a strobe every register keeps its value.
- R3: Mode 0 (main control bits 2:0 = 0) maps one 32 KB bank to 0x8000-0xFFFF. The bank is bank3[2:0] + 8·outer[2:0], and the page is bank·4 + A[14:13].
- R4: Mode 1 maps two 16 KB halves, and the page is bank·2 + A[13]. At 0x8000 the bank is bank1[3:0] + 16·outer[2:0]. At 0xC000 the bank is 15 + 16·outer[2:0].
- R5: Modes 2 and 3 map four 8 KB slots. Slots 0x8000, 0xA000 and 0xC000 take bank0, bank1 and bank2. Slot 0xE000 is fixed at 31. Each slot value uses its low 5 bits plus 32·outer[2:0].
- R6: Mode 4 maps one 32 KB bank, bank3[3:0] + 16·outer[2:1], and the page is bank·4 + A[14:13].
- R7: Mode 5 maps 16 KB halves, with bank1 at 0x8000 and bank3 at 0xC000. Each bank is reg[4:0] + 32·outer[2:1], and the page is bank·2 + A[13].
- R8: Modes 6 and 7 map four 8 KB slots from bank0 to bank3, selected by A[14:13]. Each page is reg[5:0] + 64·outer[2:1].
- R9: With main control bit 7 set, 0x6000-0x7FFF hits ROM, and the page depends on the mode. Modes 0 and 4 give (bank3[3:0]·4+3) + 64·outer[2:1]. Modes 1 and 5 give (bank3[4:0]·2+1) + 64·outer[2:1]. Modes 2 and 3 give bank3[4:0] + 32·outer[2:0]. Modes 6 and 7 give bank3[5:0] + 64·outer[2:1].
- R10: `rom_hit` is 1 for every address in 0x8000-0xFFFF. It is 0 in 0x6000-0x7FFF while main control bit 7 is clear. It is 0 for any address below 0x6000. Whenever `rom_hit` is 0, `page` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_we | input | 1 | Load bank register `wr_idx` |
| ctl_we | input | 1 | Load main control byte |
| outer_we | input | 1 | Load outer control byte |
| wr_idx | input | 2 | Bank register index |
| wr_data | input | 8 | Write data |
| cpu_addr | input | 16 | CPU address being translated |
| rom_hit | output | 1 | Address maps to program ROM |
| page | output | 8 | 8 KB ROM page number |

## Verification
The hardest case to reach is the 0x6000 window in the modes where the window page is computed arithmetically from bank3 rather than copied. In those modes a carry or a dropped bit only shows when bank3 has high bits set and the outer byte has its top bits set as well. The stimulus therefore loads bank3 with values whose upper bits would spill past the mask. It then walks every mode with the window open and with two different outer bytes, probing both ends of each slot so that the appended address bits are also seen.

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper #(
  parameter logic [7:0] BANK_RST = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bank_we,
  input  logic        ctl_we,
  input  logic        outer_we,
  input  logic [1:0]  wr_idx,
  input  logic [7:0]  wr_data,
  input  logic [15:0] cpu_addr,
  output logic        rom_hit,
  output logic [7:0]  page
);
  logic [7:0] bank_q [4];
  logic [7:0] ctl_q, outer_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) bank_q[i] <= BANK_RST;
      ctl_q   <= '0;
      outer_q <= '0;
    end else begin
      if (bank_we)  bank_q[wr_idx] <= wr_data;
      if (ctl_we)   ctl_q   <= wr_data;
      if (outer_we) outer_q <= wr_data;
    end
  end

  wire [2:0] mode   = ctl_q[2:0];
  wire [1:0] slot   = cpu_addr[14:13];
  wire       in_hi  = cpu_addr[15];
  wire       in_win = cpu_addr[15:13] == 3'b011;
  wire [2:0] o3     = outer_q[2:0];
  wire [1:0] o2     = outer_q[2:1];
  wire [7:0] r3     = bank_q[3];
  wire [7:0] rs     = bank_q[slot];
  wire [7:0] r16    = cpu_addr[14] ? r3 : bank_q[1];

  logic [7:0] hi_page, win_page;

  always_comb begin
    unique case (mode)
      3'd0: hi_page = {o3, r3[2:0], slot};
      3'd1: hi_page = cpu_addr[14] ? {o3, 4'hF, cpu_addr[13]}
                                   : {o3, bank_q[1][3:0], cpu_addr[13]};
      3'd2,
      3'd3: hi_page = (slot == 2'd3) ? {o3, 5'h1F} : {o3, rs[4:0]};
      3'd4: hi_page = {o2, r3[3:0], slot};
      3'd5: hi_page = {o2, r16[4:0], cpu_addr[13]};
      default: hi_page = {o2, rs[5:0]};
    endcase
  end

  always_comb begin
    unique case (mode)
      3'd0, 3'd4: win_page = {o2, r3[3:0], 2'b11};
      3'd1, 3'd5: win_page = {o2, r3[4:0], 1'b1};
      3'd2, 3'd3: win_page = {o3, r3[4:0]};
      default:    win_page = {o2, r3[5:0]};
    endcase
  end

  assign rom_hit = in_hi | (in_win & ctl_q[7]);
  assign page    = in_hi ? hi_page : (rom_hit ? win_page : 8'h00);
endmodule

module prg_bank_mapper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bank_we,
  input logic        ctl_we,
  input logic        outer_we,
  input logic [1:0]  wr_idx,
  input logic [7:0]  wr_data,
  input logic [15:0] cpu_addr,
  input logic        rom_hit,
  input logic [7:0]  page,
  input logic [7:0]  ctl_q
);
  wire no_wr = !bank_we && !ctl_we && !outer_we;

  assert_low_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr < 16'h6000 |-> !rom_hit && page == 8'h00);

  assert_hi_mapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[15] |-> rom_hit);

  assert_win_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:13] == 3'b011 && !ctl_q[7]) |-> !rom_hit);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(no_wr) && $stable(cpu_addr)) |-> $stable(page) && $stable(rom_hit));

  assert_fixed_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[2:1] == 2'b01 && cpu_addr[15:13] == 3'b111) |-> page[4:0] == 5'h1F);

  assert_fixed_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[2:0] == 3'd1 && cpu_addr[15:14] == 2'b11) |-> page[4:1] == 4'hF);

  assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bank_we) && !$past(ctl_we) && !$past(outer_we) && $past(wr_idx) == 2'd0 &&
     ctl_q[2:1] == 2'b11 && cpu_addr[15:13] == 3'b100) |-> page[5:0] == $past(wr_data[5:0]));
endmodule

bind prg_bank_mapper prg_bank_mapper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bank_we(bank_we), .ctl_we(ctl_we), .outer_we(outer_we),
  .wr_idx(wr_idx), .wr_data(wr_data), .cpu_addr(cpu_addr), .rom_hit(rom_hit),
  .page(page), .ctl_q(ctl_q)
);

// File: tb/sim_prg_bank_mapper.sv
module sim_prg_bank_mapper;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bank_we = 0, ctl_we = 0, outer_we = 0;
  logic [1:0]  wr_idx = 0;
  logic [7:0]  wr_data = 0;
  logic [15:0] cpu_addr = 0;
  logic        rom_hit;
  logic [7:0]  page;

  int checks = 0, failures = 0;
  logic [7:0] mr [4];
  logic [7:0] mc, mo;

  prg_bank_mapper u0 (.*);

  always #2 clk = ~clk;

  function automatic int exp_page(input logic [15:0] a);
    int m = mc[2:0];
    int o7 = mo & 7, o6 = mo & 6;
    int s = a[14:13];
    int b;
    if (a < 16'h6000) return 0;
    if (a < 16'h8000) begin
      if (!mc[7]) return 0;
      case (m)
        0, 4: return (((mr[3] & 15) * 4 + 3) + o6 * 32);
        1, 5: return (((mr[3] & 31) * 2 + 1) + o6 * 32);
        2, 3: return ((mr[3] & 31) + o7 * 32);
        default: return ((mr[3] & 63) + o6 * 32);
      endcase
    end
    case (m)
      0: begin b = (mr[3] & 7) + o7 * 8; return b * 4 + s; end
      1: begin b = a[14] ? 15 + o7 * 16 : (mr[1] & 15) + o7 * 16; return b * 2 + a[13]; end
      2, 3: return (s == 3 ? 31 : (mr[s] & 31)) + o7 * 32;
      4: begin b = (mr[3] & 15) + o6 * 8; return b * 4 + s; end
      5: begin b = ((a[14] ? mr[3] : mr[1]) & 31) + o6 * 16; return b * 2 + a[13]; end
      default: return (mr[s] & 63) + o6 * 32;
    endcase
  endfunction

  function automatic bit exp_hit(input logic [15:0] a);
    return a[15] || (a[15:13] == 3'b011 && mc[7]);
  endfunction

  task automatic chk(input string tag, input logic [15:0] a);
    int ep;
    bit eh;
    cpu_addr = a;
    #1;
    ep = exp_page(a);
    eh = exp_hit(a);
    checks++;
    if (page !== ep[7:0] || rom_hit !== eh) begin
      failures++;
      $display("FAIL %s addr=%h actual page=%h hit=%b expected page=%h hit=%b",
               tag, a, page, rom_hit, ep[7:0], eh);
    end
  endtask

  task automatic wr(input int kind, input logic [1:0] idx, input logic [7:0] d);
    @(negedge clk);
    bank_we = (kind == 0); ctl_we = (kind == 1); outer_we = (kind == 2);
    wr_idx = idx; wr_data = d;
    @(negedge clk);
    bank_we = 0; ctl_we = 0; outer_we = 0;
    if (kind == 0) mr[idx] = d;
    else if (kind == 1) mc = d;
    else mo = d;
  endtask

  task automatic sweep(input string tag);
    chk(tag, 16'h6000); chk(tag, 16'h7FFF);
    chk(tag, 16'h8000); chk(tag, 16'h9FFF);
    chk(tag, 16'hA000); chk(tag, 16'hC000);
    chk(tag, 16'hDFFF); chk(tag, 16'hE000);
    chk(tag, 16'hFFFF);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 4; i++) mr[i] = 8'hFF;
    mc = 0; mo = 0;
    sweep("R1");
    chk("R10", 16'h0000); chk("R10", 16'h5FFF);
  endtask

  task automatic t_writes;
    wr(0, 2'd0, 8'hA5); wr(0, 2'd1, 8'h5A);
    wr(0, 2'd2, 8'hC3); wr(0, 2'd3, 8'h3E);
    wr(1, 2'd0, 8'h06);
    sweep("R2");
    @(negedge clk);
    wr_data = 8'h00; wr_idx = 2'd2;
    @(negedge clk);
    sweep("R2");
  endtask

  task automatic t_mode(input int m, input string tag);
    for (int k = 0; k < 3; k++) begin
      wr(2, 2'd0, k == 0 ? 8'h00 : (k == 1 ? 8'h05 : 8'hFE));
      wr(1, 2'd0, 8'(m));
      sweep(tag);
      chk("R10", 16'h4000);
      wr(1, 2'd0, 8'(m) | 8'h80);
      chk("R9", 16'h6000); chk("R9", 16'h7FFF);
      chk("R10", 16'h5FFF);
    end
  endtask

  task automatic t_window_hard;
    wr(0, 2'd3, 8'hFF);
    wr(2, 2'd0, 8'h07);
    for (int m = 0; m < 8; m++) begin
      wr(1, 2'd0, 8'(m) | 8'h80);
      chk("R9", 16'h6000);
      chk("R9", 16'h7123);
    end
    wr(0, 2'd3, 8'h9C);
    for (int m = 0; m < 8; m++) begin
      wr(1, 2'd0, 8'(m) | 8'h80);
      chk("R9", 16'h6ABC);
      wr(1, 2'd0, 8'(m));
      chk("R10", 16'h6ABC);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_writes;
    wr(0, 2'd0, 8'h2B); wr(0, 2'd1, 8'hD7);
    wr(0, 2'd2, 8'h69); wr(0, 2'd3, 8'hB6);
    t_mode(0, "R3");
    t_mode(1, "R4");
    t_mode(2, "R5");
    t_mode(3, "R5");
    t_mode(4, "R6");
    t_mode(5, "R7");
    t_mode(6, "R8");
    t_mode(7, "R8");
    t_window_hard;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule